// File: doc/BRIEF.md
# I2C Slave Controller with Event Status Codes

This block is the slave half of a two-wire (I2C) serial interface. It watches SCL and SDA for START and STOP conditions and shifts in each address byte. It compares the 7-bit address against a programmable own address and can also answer the general-call address 00h. Once addressed, it either receives data bytes from the master or sends bytes from its transmit register. It drives SDA and SCL only open-drain: a high output means "pull the line low".

Every bus event that software must handle is reported in two ways. An 8-bit status code describes the event, and an interrupt flag is set. Software reads the code, services the event and clears the flag by writing 0 to it. While the flag is pending for a data or address event, the block holds SCL low, so the master waits. An acknowledge-enable bit lets software detach the slave from the bus without losing track of the bus. An input from the master side selects the alternate entry codes used when the slave is addressed just after losing arbitration.

Software access is a simple write port with a 2-bit select:
- Select 0 is the own-address register.
- Select 1 is the control register.
- Select 2 is the transmit data register.

The status code, the flag and the last received byte are plain outputs.

Top module: `i2c_status_slave`

## Requirements
- R1: After reset, status_o is F8h, irq_o is 0, and neither scl_pull_o nor sda_pull_o is asserted.
- R2: Suppose the own-address register (select 0) holds the address in bits 7..1, and the control register (select 1) has bit 0 (enable) and bit 1 (acknowledge-enable) set. Then an address byte that matches with direction bit 0 is ACKed, and the event reports status 60h with irq_o set.
- R3: When bit 0 of the own-address register is 1, address byte 00h is ACKed and reports 70h. When that bit is 0, 00h is NACKed and irq_o stays 0.
- R4: An address byte that matches neither the own address nor an enabled general call is NACKed and raises no event.
- R5: While addressed for writing, each received data byte is ACKed and appears on rx_data_o. The status is 80h after own-address entry and 90h after general-call entry.
- R6: If acknowledge-enable is 0 when a data byte completes, that byte is NACKed and reported as 88h (own) or 98h (general call). The slave then leaves the addressed state, so a following STOP raises no event.
- R7: While acknowledge-enable is 0, the own address is NACKed with no event. After the bit is set again, the next address phase is recognised normally.
- R8: An own-address match with direction bit 1 reports A8h. Each byte is then sent MSB first from the transmit register (select 2), loaded when the flag is cleared. A master ACK reports B8h. A master NACK reports C0h, after which the slave releases SDA and is no longer addressed.
- R9: A STOP or a repeated START while addressed as receiver reports A0h and does not hold SCL low.
- R10: When lost_arb_i is 1, an own-address write entry reports 68h instead of 60h, and a general-call entry reports 78h instead of 70h.
- R11: After any event other than A0h, SCL is held low while irq_o is 1. Writing the control register with bit 2 at 0 clears the flag and releases SCL. Writing bit 2 as 1 leaves the flag unchanged.
- R12: Whenever irq_o is 0, status_o reads F8h.
- R13: Control register bits 7..5 (bit-rate selection) have no effect on slave operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 own address, 1 control, 2 transmit data |
| reg_wdata | input | 8 | Register write data |
| lost_arb_i | input | 1 | Selects the after-lost-arbitration entry codes |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| status_o | output | 8 | Event status code |
| irq_o | output | 1 | Interrupt flag |
| rx_data_o | output | 8 | Last received data byte |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default of 2. The extra stage adds one cycle between each real bus edge and its detection inside the block. This shows that ACK driving, SDA changes on transmit and clock stretching still fall inside the SCL low phase when the detection latency is larger. The bench's bus master uses a half-bit time of 16 clocks and honours stretching, so each data byte can be held off indefinitely by a pending flag. This lets the bench check that SCL stays low while software delays the flag clear.

// File: rtl/i2cs_pkg.sv
// Package: shared constants and state type for the I2C status-code slave.
// Assumes 8-bit bytes and a fixed 2-bit register select.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // register select values
    localparam logic [SEL_W-1:0] SEL_OWN  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd1;
    localparam logic [SEL_W-1:0] SEL_TX   = 2'd2;

    // control register bit positions
    localparam int CTRL_EN = 0;
    localparam int CTRL_AA = 1;
    localparam int CTRL_SI = 2;

    // status codes
    localparam logic [7:0] ST_OWN_W     = 8'h60;
    localparam logic [7:0] ST_OWN_W_AL  = 8'h68;
    localparam logic [7:0] ST_GC        = 8'h70;
    localparam logic [7:0] ST_GC_AL     = 8'h78;
    localparam logic [7:0] ST_OWN_D_ACK = 8'h80;
    localparam logic [7:0] ST_OWN_D_NAK = 8'h88;
    localparam logic [7:0] ST_GC_D_ACK  = 8'h90;
    localparam logic [7:0] ST_GC_D_NAK  = 8'h98;
    localparam logic [7:0] ST_STOP      = 8'hA0;
    localparam logic [7:0] ST_OWN_R     = 8'hA8;
    localparam logic [7:0] ST_TX_ACK    = 8'hB8;
    localparam logic [7:0] ST_TX_NAK    = 8'hC0;
    localparam logic [7:0] ST_NONE      = 8'hF8;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TXW, S_TX, S_TACK
    } slv_state_e;
endpackage

// File: rtl/i2cs_bus_mon.sv
// Bus monitor: brings SCL and SDA into the clock domain through a
// SYNC_STAGES-deep chain and derives SCL edges plus START/STOP pulses.
// Assumes SYNC_STAGES >= 2 and that the bus idles high.
module i2cs_bus_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_s_o
);
    logic [SYNC_STAGES-1:0][1:0] stg_q;
    logic scl_d_q, sda_d_q, scl_s, sda_s;

    // shift {scl, sda} through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else begin
            stg_q[0] <= {scl_i, sda_i};
            for (int k = 1; k < SYNC_STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign scl_s = stg_q[SYNC_STAGES-1][1];
    assign sda_s = stg_q[SYNC_STAGES-1][0];

    // keep the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d_q <= 1'b1;
            sda_d_q <= 1'b1;
        end else begin
            scl_d_q <= scl_s;
            sda_d_q <= sda_s;
        end
    end

    assign scl_rise_o = scl_s & ~scl_d_q;
    assign scl_fall_o = ~scl_s & scl_d_q;
    assign start_o    = scl_s & scl_d_q & sda_d_q & ~sda_s;
    assign stop_o     = scl_s & scl_d_q & ~sda_d_q & sda_s;
    assign sda_s_o    = sda_s;
endmodule

// File: rtl/i2cs_fsm.sv
// Protocol sequencer: follows address and data phases on synchronised
// bus events, drives ACK and transmit bits on SDA, and issues one-cycle
// event pulses carrying a status code and a stretch request.
// Assumes SDA is only changed while SCL is low.
module i2cs_fsm
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              aa_i,
    input  logic [BYTE_W-1:0] own_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic              si_i,
    input  logic              lost_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    output logic              sda_low_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              ev_valid_o,
    output logic [7:0]        ev_code_o,
    output logic              ev_hold_o
);
    slv_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              rw_q, gc_q, ack_q;
    logic              own_hit, gc_hit, byte_done;

    // address comparison against the shifted-in byte
    always_comb begin
        own_hit   = aa_i && (sh_q[BYTE_W-1:1] == own_i[BYTE_W-1:1]);
        gc_hit    = aa_i && own_i[0] && (sh_q == '0);
        byte_done = (cnt_q == CNT_W'(BYTE_W));
    end

    // bus protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cnt_q      <= '0;
            sh_q       <= '0;
            rw_q       <= 1'b0;
            gc_q       <= 1'b0;
            ack_q      <= 1'b0;
            sda_low_o  <= 1'b0;
            rx_byte_o  <= '0;
            ev_valid_o <= 1'b0;
            ev_code_o  <= ST_NONE;
            ev_hold_o  <= 1'b0;
        end else begin
            ev_valid_o <= 1'b0;
            if (!en_i) begin
                state_q   <= S_IDLE;
                sda_low_o <= 1'b0;
            end else if (start_i || stop_i) begin
                if (state_q == S_RX) begin
                    ev_valid_o <= 1'b1;
                    ev_code_o  <= ST_STOP;
                    ev_hold_o  <= 1'b0;
                end
                state_q   <= start_i ? S_ADDR : S_IDLE;
                cnt_q     <= '0;
                sda_low_o <= 1'b0;
            end else begin
                unique case (state_q)
                    S_ADDR: begin
                        if (scl_rise_i) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall_i && byte_done) begin
                            if (own_hit || gc_hit) begin
                                sda_low_o <= 1'b1;
                                gc_q      <= !own_hit;
                                rw_q      <= sh_q[0];
                                state_q   <= S_AACK;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    S_AACK: begin
                        if (scl_fall_i) begin
                            sda_low_o  <= 1'b0;
                            ev_valid_o <= 1'b1;
                            ev_hold_o  <= 1'b1;
                            cnt_q      <= '0;
                            if (rw_q) begin
                                ev_code_o <= ST_OWN_R;
                                state_q   <= S_TXW;
                            end else begin
                                ev_code_o <= gc_q ? (lost_i ? ST_GC_AL : ST_GC)
                                                  : (lost_i ? ST_OWN_W_AL : ST_OWN_W);
                                state_q   <= S_RX;
                            end
                        end
                    end
                    S_RX: begin
                        if (scl_rise_i) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall_i && byte_done) begin
                            ack_q     <= aa_i;
                            sda_low_o <= aa_i;
                            state_q   <= S_RACK;
                        end
                    end
                    S_RACK: begin
                        if (scl_fall_i) begin
                            sda_low_o  <= 1'b0;
                            rx_byte_o  <= sh_q;
                            ev_valid_o <= 1'b1;
                            ev_hold_o  <= 1'b1;
                            ev_code_o  <= gc_q ? (ack_q ? ST_GC_D_ACK : ST_GC_D_NAK)
                                               : (ack_q ? ST_OWN_D_ACK : ST_OWN_D_NAK);
                            cnt_q      <= '0;
                            state_q    <= ack_q ? S_RX : S_IDLE;
                        end
                    end
                    S_TXW: begin
                        sda_low_o <= ~tx_i[BYTE_W-1];
                        if (!si_i && !ev_valid_o) begin
                            sh_q    <= tx_i;
                            cnt_q   <= '0;
                            state_q <= S_TX;
                        end
                    end
                    S_TX: begin
                        sda_low_o <= ~sh_q[BYTE_W-1];
                        if (scl_rise_i) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall_i) begin
                            if (byte_done) begin
                                sda_low_o <= 1'b0;
                                state_q   <= S_TACK;
                            end else begin
                                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    S_TACK: begin
                        if (scl_rise_i) begin
                            ack_q <= !sda_i;
                        end else if (scl_fall_i) begin
                            ev_valid_o <= 1'b1;
                            ev_hold_o  <= 1'b1;
                            ev_code_o  <= ack_q ? ST_TX_ACK : ST_TX_NAK;
                            state_q    <= ack_q ? S_TXW : S_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_regs.sv
// Register and flag block: holds own address, control bits and transmit
// byte; keeps the interrupt flag, status code and stretch request.
// Assumes event pulses win over a same-cycle software flag clear.
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              ev_valid_i,
    input  logic [7:0]        ev_code_i,
    input  logic              ev_hold_i,
    output logic [BYTE_W-1:0] own_o,
    output logic [BYTE_W-1:0] tx_o,
    output logic              en_o,
    output logic              aa_o,
    output logic              si_o,
    output logic [7:0]        status_o,
    output logic              scl_hold_o
);
    logic clr_w, hold_q;

    assign clr_w = reg_we && (reg_sel == SEL_CTRL) && !reg_wdata[CTRL_SI];

    // software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_o <= '0;
            tx_o  <= '0;
            en_o  <= 1'b0;
            aa_o  <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_OWN:  own_o <= reg_wdata;
                SEL_TX:   tx_o  <= reg_wdata;
                SEL_CTRL: begin
                    en_o <= reg_wdata[CTRL_EN];
                    aa_o <= reg_wdata[CTRL_AA];
                end
                default: ;
            endcase
        end
    end

    // interrupt flag, status code and stretch request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_o     <= 1'b0;
            status_o <= ST_NONE;
            hold_q   <= 1'b0;
        end else if (ev_valid_i) begin
            si_o     <= 1'b1;
            status_o <= ev_code_i;
            hold_q   <= ev_hold_i;
        end else if (clr_w) begin
            si_o     <= 1'b0;
            status_o <= ST_NONE;
            hold_q   <= 1'b0;
        end
    end

    assign scl_hold_o = si_o & hold_q;
endmodule

// File: rtl/i2c_status_slave.sv
// Top: I2C slave controller reporting each bus event as a status code
// with a software-cleared flag; stretches SCL while the flag is pending.
// Assumes open-drain pads outside (1 on a pull output drives the line low).
module i2c_status_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       lost_arb_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull_o,
    output logic       sda_pull_o,
    output logic [7:0] status_o,
    output logic       irq_o,
    output logic [7:0] rx_data_o
);
    logic scl_rise, scl_fall, start_p, stop_p, sda_s;
    logic en, aa, si, ev_valid, ev_hold;
    logic [BYTE_W-1:0] own, tx;
    logic [7:0] ev_code;

    i2cs_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_p), .stop_o(stop_p), .sda_s_o(sda_s)
    );

    i2cs_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .aa_i(aa), .own_i(own),
        .tx_i(tx), .si_i(si), .lost_i(lost_arb_i),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_p), .stop_i(stop_p), .sda_i(sda_s),
        .sda_low_o(sda_pull_o), .rx_byte_o(rx_data_o),
        .ev_valid_o(ev_valid), .ev_code_o(ev_code), .ev_hold_o(ev_hold)
    );

    i2cs_regs regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ev_valid_i(ev_valid), .ev_code_i(ev_code),
        .ev_hold_i(ev_hold), .own_o(own), .tx_o(tx), .en_o(en), .aa_o(aa),
        .si_o(si), .status_o(status_o), .scl_hold_o(scl_pull_o)
    );

    assign irq_o = si;
endmodule

// File: rtl/i2c_status_slave_chk.sv
// Checker: temporal properties on the slave's ports, bound to the top.
module i2c_status_slave_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_sel,
    input logic [7:0] reg_wdata,
    input logic       scl_pull_o,
    input logic [7:0] status_o,
    input logic       irq_o
);
    // R11
    stretch_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_o |-> irq_o);

    // R12
    idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> status_o == ST_NONE);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(reg_we && reg_sel == SEL_CTRL && !reg_wdata[CTRL_SI])) |=> irq_o);

    // R11
    stretch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_o) |-> $rose(irq_o));

    // R9
    stop_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && status_o == ST_STOP) |-> !scl_pull_o);
endmodule

bind i2c_status_slave i2c_status_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .scl_pull_o(scl_pull_o), .status_o(status_o),
    .irq_o(irq_o)
);

// File: tb/i2c_status_slave_tb_top.sv
// Scoreboard bench: the driver pushes expected status events before each
// bus action; a monitor pops and compares on every rising flag.
module i2c_status_slave_tb_top;
    localparam int HB = 16;

    typedef struct {
        logic [7:0] code;
        logic [7:0] data;
        bit         use_data;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic lost_arb = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_pull, sda_pull, irq;
    logic [7:0] status, rx_data;
    wire  scl_ln = scl_m & ~scl_pull;
    wire  sda_ln = sda_m & ~sda_pull;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit irq_prev = 1'b0;
    exp_t exp_q[$];
    exp_t mon_e;

    always #4 clk = ~clk;

    i2c_status_slave #(.SYNC_STAGES(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .lost_arb_i(lost_arb), .scl_i(scl_ln),
        .sda_i(sda_ln), .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
        .status_o(status), .irq_o(irq), .rx_data_o(rx_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] code, input logic [7:0] data,
                        input bit use_data, input string req);
        exp_t e;
        e.code = code; e.data = data; e.use_data = use_data; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: compare each new event against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (irq && !irq_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected event", status, 8'hF8);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(status == mon_e.code, mon_e.req, "status", status, mon_e.code);
                    if (mon_e.use_data)
                        chk(rx_data == mon_e.data, mon_e.req, "rx data", rx_data, mon_e.data);
                end
            end
            irq_prev = irq;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 8'h00, 8'h01);
        finish_run();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_ln) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        if (!irq) chk(1'b0, req, "flag never set", {7'd0, irq}, 8'h01);
    endtask

    // ctrl value: rate bits 7..5 set, bit2 flag=0, bit1 AA, bit0 enable
    task automatic sw_clear(input logic aa, input string req);
        wait_irq(req);
        cyc(3);
        reg_write(2'd1, {3'b111, 2'b00, 1'b0, aa, 1'b1});
    endtask

    task automatic m_start();
        sda_m = 1'b1; cyc(HB);
        scl_m = 1'b1; wait_high(); cyc(HB);
        sda_m = 1'b0; cyc(HB);
        scl_m = 1'b0; cyc(4);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; cyc(HB);
        scl_m = 1'b1; wait_high(); cyc(HB);
        sda_m = 1'b1; cyc(HB);
    endtask

    task automatic m_bit_w(input logic b);
        sda_m = b; cyc(HB);
        scl_m = 1'b1; wait_high(); cyc(HB);
        scl_m = 1'b0; cyc(4);
    endtask

    task automatic m_bit_r(output logic b);
        sda_m = 1'b1; cyc(HB);
        scl_m = 1'b1; wait_high(); cyc(HB / 2);
        b = sda_ln; cyc(HB / 2);
        scl_m = 1'b0; cyc(4);
    endtask

    task automatic m_write(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(b);
        ack = !b;
    endtask

    task automatic m_read(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_bit_r(b); d[i] = b; end
        m_bit_w(!ack);
    endtask

    initial begin
        logic ack;
        logic [7:0] rd;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk(status == 8'hF8, "R1", "status", status, 8'hF8);
        chk(irq == 1'b0, "R1", "flag", {7'd0, irq}, 8'h00);
        chk(!scl_pull && !sda_pull, "R1", "pulls", {6'd0, scl_pull, sda_pull}, 8'h00);

        // own address 5Ah with general call; control with rate bits set (R13)
        reg_write(2'd0, 8'hB5);
        reg_write(2'd1, 8'hE3);

        // R2, R5, R11, R13: write transfer
        push(8'h60, 8'h00, 0, "R2");
        m_start(); m_write(8'hB4, ack);
        chk(ack, "R2", "address ack", {7'd0, ack}, 8'h01);
        sw_clear(1'b1, "R2");
        push(8'h80, 8'h3C, 1, "R5");
        m_write(8'h3C, ack);
        chk(ack, "R13", "data ack with rate bits set", {7'd0, ack}, 8'h01);
        push(8'h80, 8'hC3, 1, "R5");
        fork
            m_write(8'hC3, ack);
            begin
                cyc(60);
                chk(scl_ln == 1'b0, "R11", "SCL held while flag set", {7'd0, scl_ln}, 8'h00);
                reg_write(2'd1, 8'hE7);
                cyc(2);
                chk(irq == 1'b1, "R11", "write of 1 keeps flag", {7'd0, irq}, 8'h01);
                reg_write(2'd1, 8'hE3);
                cyc(3);
                chk(status == 8'hF8, "R12", "status after clear", status, 8'hF8);
                chk(scl_pull == 1'b0, "R11", "SCL released", {7'd0, scl_pull}, 8'h00);
            end
        join
        chk(ack, "R5", "second data ack", {7'd0, ack}, 8'h01);
        sw_clear(1'b1, "R5");
        push(8'hA0, 8'h00, 0, "R9");
        m_stop();
        wait_irq("R9");
        chk(scl_pull == 1'b0, "R9", "no stretch on stop", {7'd0, scl_pull}, 8'h00);
        sw_clear(1'b1, "R9");

        // R6: AA cleared mid-transfer
        push(8'h60, 8'h00, 0, "R6");
        m_start(); m_write(8'hB4, ack);
        sw_clear(1'b0, "R6");
        push(8'h88, 8'h11, 1, "R6");
        m_write(8'h11, ack);
        chk(!ack, "R6", "data nack", {7'd0, ack}, 8'h00);
        sw_clear(1'b0, "R6");
        m_stop(); cyc(50);
        chk(irq == 1'b0, "R6", "no event after stop", {7'd0, irq}, 8'h00);

        // R7: AA off isolates, then resume
        m_start(); m_write(8'hB4, ack);
        chk(!ack, "R7", "address nack with AA off", {7'd0, ack}, 8'h00);
        m_stop(); cyc(50);
        chk(irq == 1'b0, "R7", "no event with AA off", {7'd0, irq}, 8'h00);
        reg_write(2'd1, 8'hE3);
        push(8'h60, 8'h00, 0, "R7");
        m_start(); m_write(8'hB4, ack);
        chk(ack, "R7", "address ack after resume", {7'd0, ack}, 8'h01);
        sw_clear(1'b1, "R7");
        push(8'hA0, 8'h00, 0, "R9");
        m_stop(); sw_clear(1'b1, "R9");

        // R3: general call enabled
        push(8'h70, 8'h00, 0, "R3");
        m_start(); m_write(8'h00, ack);
        chk(ack, "R3", "general call ack", {7'd0, ack}, 8'h01);
        sw_clear(1'b1, "R3");
        push(8'h90, 8'h77, 1, "R5");
        m_write(8'h77, ack);
        sw_clear(1'b1, "R5");
        push(8'hA0, 8'h00, 0, "R9");
        m_stop(); sw_clear(1'b1, "R9");

        // R3: general call disabled
        reg_write(2'd0, 8'hB4);
        m_start(); m_write(8'h00, ack);
        chk(!ack, "R3", "general call nack when disabled", {7'd0, ack}, 8'h00);
        m_stop(); cyc(50);
        chk(irq == 1'b0, "R3", "no event when disabled", {7'd0, irq}, 8'h00);

        // R4: other address
        m_start(); m_write(8'hB6, ack);
        chk(!ack, "R4", "foreign address nack", {7'd0, ack}, 8'h00);
        m_stop(); cyc(50);
        chk(irq == 1'b0, "R4", "no event", {7'd0, irq}, 8'h00);

        // R8: slave transmitter
        reg_write(2'd0, 8'hB5);
        push(8'hA8, 8'h00, 0, "R8");
        m_start(); m_write(8'hB5, ack);
        chk(ack, "R8", "read address ack", {7'd0, ack}, 8'h01);
        wait_irq("R8");
        reg_write(2'd2, 8'hA5);
        sw_clear(1'b1, "R8");
        push(8'hB8, 8'h00, 0, "R8");
        m_read(rd, 1'b1);
        chk(rd == 8'hA5, "R8", "first byte", rd, 8'hA5);
        wait_irq("R8");
        reg_write(2'd2, 8'h3E);
        sw_clear(1'b1, "R8");
        push(8'hC0, 8'h00, 0, "R8");
        m_read(rd, 1'b0);
        chk(rd == 8'h3E, "R8", "second byte", rd, 8'h3E);
        sw_clear(1'b1, "R8");
        cyc(4);
        chk(sda_pull == 1'b0, "R8", "SDA released after nack", {7'd0, sda_pull}, 8'h00);
        m_stop(); cyc(50);
        chk(irq == 1'b0, "R8", "not addressed after nack", {7'd0, irq}, 8'h00);

        // R10: entry after lost arbitration
        lost_arb = 1'b1;
        push(8'h68, 8'h00, 0, "R10");
        m_start(); m_write(8'hB4, ack);
        sw_clear(1'b1, "R10");
        push(8'hA0, 8'h00, 0, "R9");
        m_stop(); sw_clear(1'b1, "R9");
        push(8'h78, 8'h00, 0, "R10");
        m_start(); m_write(8'h00, ack);
        sw_clear(1'b1, "R10");
        push(8'hA0, 8'h00, 0, "R9");
        m_stop(); sw_clear(1'b1, "R9");
        lost_arb = 1'b0;

        // R9: repeated start while addressed, then read
        push(8'h60, 8'h00, 0, "R9");
        m_start(); m_write(8'hB4, ack);
        sw_clear(1'b1, "R9");
        push(8'hA0, 8'h00, 0, "R9");
        m_start();
        sw_clear(1'b1, "R9");
        push(8'hA8, 8'h00, 0, "R8");
        m_write(8'hB5, ack);
        wait_irq("R8");
        reg_write(2'd2, 8'h5A);
        sw_clear(1'b1, "R8");
        push(8'hC0, 8'h00, 0, "R8");
        m_read(rd, 1'b0);
        chk(rd == 8'h5A, "R8", "byte after repeated start", rd, 8'h5A);
        sw_clear(1'b1, "R8");
        m_stop();

        cyc(50);
        chk(exp_q.size() == 0, "R2", "all expected events seen", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule